// File: doc/BRIEF.md
# Externally Timed Burst and Step Sweep Sequencer

This block sequences a stepped frequency sweep for a direct digital synthesis core. It produces the frequency word that the phase accumulator uses, a gate that either lets the synthesised waveform through or parks the output at midscale, an enable for the accumulator, and one status line. One external pin times both the steps and the bursts. A rising edge on that pin starts the sweep at the start frequency. Each later rising edge moves the frequency by one signed step, until the programmed number of steps has been taken. After that the final word is held.

In the externally gated burst mode, the pin's high time is the burst length and its low time is the midscale listening gap. In continuous mode the gate stays open for the whole sweep, whatever level the pin has. An interrupt pin aborts the sweep and returns the output to midscale. A standby pin freezes the sequencer and stops the accumulator. The timing pin, the interrupt pin and the standby pin all pass through a two-flop synchroniser before they act. The status line can show either the end of the sweep or a short pulse at each step.

Top module: `burst_sweep_seq`

## Requirements
- R1: After reset, freqWord is 0 and outGate, accumEnable and statusOut are all 0.
- R2: From the idle state, a rising edge on ctrlPin starts the sweep. freqWord becomes startFreq and accumEnable becomes 1. With cfgContinuous=0 and cfgExtBurst=1, outGate is 1 while ctrlPin is high.
- R3: With cfgContinuous=0 and cfgExtBurst=1, outGate is 0 (midscale) while ctrlPin is low during a sweep. accumEnable stays 1.
- R4: With cfgExtIncr=1, each rising edge of ctrlPin after the first adds deltaFreq (two's complement, so it may be negative) to freqWord.
- R5: Once numIncr steps have been taken, further rising edges leave freqWord unchanged.
- R6: With cfgContinuous=1, outGate stays 1 for the whole sweep, whatever level ctrlPin has.
- R7: With cfgExtIncr=0, rising edges after the first leave freqWord at startFreq.
- R8: A rising edge on intrPin returns the block to idle. outGate and accumEnable go to 0 and freqWord goes to 0. When the interrupt edge and a ctrlPin edge arrive in the same cycle, the interrupt wins.
- R9: While standbyPin is high, accumEnable is 0 and freqWord and outGate hold their values. A ctrlPin level change made during standby takes effect after standby is released.
- R10: With statusEnable=0, statusOut stays 0.
- R11: With statusEnable=1 and statusMode=1, each frequency step drives statusOut high for exactly 4 clock cycles. The first edge, which loads the start frequency, gives no pulse.
- R12: With statusEnable=1 and statusMode=0, statusOut is 1 exactly while a running sweep has taken all of its steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfgContinuous | input | 1 | 1: gate open for the whole sweep; 0: burst gating |
| cfgExtBurst | input | 1 | 1: the ctrlPin level sets the burst and listen times |
| cfgExtIncr | input | 1 | 1: each ctrlPin rising edge steps the frequency |
| statusEnable | input | 1 | Enables statusOut |
| statusMode | input | 1 | 1: pulse at each step; 0: end-of-sweep level |
| startFreq | input | FREQ_W | First frequency word of the sweep |
| deltaFreq | input | FREQ_W | Signed step added at each increment |
| numIncr | input | CNT_W | Number of steps in the sweep |
| ctrlPin | input | 1 | Asynchronous burst/step timing pin |
| intrPin | input | 1 | Asynchronous interrupt; its rising edge aborts the sweep |
| standbyPin | input | 1 | Asynchronous freeze request |
| freqWord | output | FREQ_W | Frequency word for the accumulator |
| outGate | output | 1 | 1: waveform out; 0: output at midscale |
| accumEnable | output | 1 | Phase accumulator advance enable |
| statusOut | output | 1 | Sweep status line |

## Verification
The sweep is driven with a positive step and with a negative step, and each is run past the last step. This separates a correct signed add and a correct end hold from wrap or overshoot errors. The same edge train is then applied in gated burst mode, in continuous mode and with stepping turned off, which tells apart a gate that follows the pin, a gate that stays open, and steps that should not happen. Interrupt and standby are applied in the middle of a sweep, and an interrupt edge is made to coincide with a start edge; these runs show the priority order and that an edge made during a freeze is kept, not lost. The status line is counted cycle by cycle in both of its modes and with it turned off.

// File: rtl/sweep_seq_pkg.sv
package sweep_seq_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} seqState_t;

  // strobes from control to the frequency datapath
  typedef struct packed {
    logic clearFreq;
    logic loadStart;
    logic stepFreq;
  } dpStrobe_t;
endpackage

// File: rtl/sweep_pin_sync.sv
module sweep_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pinAsync,
  output logic pinSync
);
  logic [STAGES-1:0] chainQ;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n) chainQ <= '0;
        else        chainQ <= pinAsync;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (!rst_n) chainQ <= '0;
        else        chainQ <= {chainQ[STAGES-2:0], pinAsync};
      end
    end
  endgenerate

  assign pinSync = chainQ[STAGES-1];
endmodule

// File: rtl/sweep_freq_path.sv
module sweep_freq_path
  import sweep_seq_pkg::*;
#(
  parameter int FREQ_W = 24,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dpStrobe_t         strobe,
  input  logic [FREQ_W-1:0] startFreq,
  input  logic [FREQ_W-1:0] deltaFreq,
  input  logic [CNT_W-1:0]  numIncr,
  output logic [FREQ_W-1:0] freqWord,
  output logic              atEnd
);
  logic [FREQ_W-1:0] freqQ;
  logic [CNT_W-1:0]  stepCntQ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      freqQ    <= '0;
      stepCntQ <= '0;
    end else if (strobe.clearFreq) begin
      freqQ    <= '0;
      stepCntQ <= '0;
    end else if (strobe.loadStart) begin
      freqQ    <= startFreq;
      stepCntQ <= '0;
    end else if (strobe.stepFreq) begin
      freqQ    <= freqQ + deltaFreq;
      stepCntQ <= stepCntQ + 1'b1;
    end
  end

  assign freqWord = freqQ;
  assign atEnd    = (stepCntQ >= numIncr);

  AST_END_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    atEnd && !strobe.clearFreq && !strobe.loadStart |=> $stable(freqQ)); // R5

  AST_STEP_DELTA: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.stepFreq && !strobe.clearFreq |=> freqQ == $past(freqQ) + $past(deltaFreq)); // R4
endmodule

// File: rtl/sweep_seq_ctrl.sv
module sweep_seq_ctrl
  import sweep_seq_pkg::*;
#(
  parameter int PULSE_CYCLES = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ctrlSync,
  input  logic      intrSync,
  input  logic      standbySync,
  input  logic      cfgContinuous,
  input  logic      cfgExtBurst,
  input  logic      cfgExtIncr,
  input  logic      statusEnable,
  input  logic      statusMode,
  input  logic      atEnd,
  output dpStrobe_t strobe,
  output logic      outGate,
  output logic      accumEnable,
  output logic      statusOut
);
  localparam int PC_W = $clog2(PULSE_CYCLES + 1);

  seqState_t       stateQ, stateD;
  logic            ctrlPrevQ, intrPrevQ;
  logic            gateQ, gateD;
  logic [PC_W-1:0] pulseCntQ, pulseCntD;
  logic            ctrlRise, intrRise, gateByCtrl;

  assign ctrlRise   = ctrlSync & ~ctrlPrevQ;
  assign intrRise   = intrSync & ~intrPrevQ;
  assign gateByCtrl = !cfgContinuous && cfgExtBurst;

  always_comb begin
    stateD    = stateQ;
    strobe    = '0;
    pulseCntD = pulseCntQ;
    if (!standbySync) begin
      if (pulseCntQ != '0) pulseCntD = pulseCntQ - 1'b1;
      if (intrRise) begin
        stateD           = ST_IDLE;
        strobe.clearFreq = 1'b1;
        pulseCntD        = '0;
      end else if (ctrlRise) begin
        if (stateQ == ST_IDLE) begin
          stateD           = ST_RUN;
          strobe.loadStart = 1'b1;
        end else if (cfgExtIncr && !atEnd) begin
          strobe.stepFreq = 1'b1;
          pulseCntD       = PC_W'(PULSE_CYCLES);
        end
      end
    end
  end

  always_comb begin
    if (standbySync) gateD = gateQ;
    else             gateD = (stateD == ST_RUN) && (gateByCtrl ? ctrlSync : 1'b1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stateQ    <= ST_IDLE;
      ctrlPrevQ <= 1'b0;
      intrPrevQ <= 1'b0;
      gateQ     <= 1'b0;
      pulseCntQ <= '0;
    end else begin
      stateQ    <= stateD;
      gateQ     <= gateD;
      pulseCntQ <= pulseCntD;
      if (!standbySync) begin
        ctrlPrevQ <= ctrlSync;
        intrPrevQ <= intrSync;
      end
    end
  end

  assign outGate     = gateQ;
  assign accumEnable = (stateQ == ST_RUN) && !standbySync;
  assign statusOut   = statusEnable &&
                       (statusMode ? (pulseCntQ != '0) : ((stateQ == ST_RUN) && atEnd));

  AST_INTR_MIDSCALE: assert property (@(posedge clk) disable iff (!rst_n)
    intrRise && !standbySync |=> !outGate && (stateQ == ST_IDLE)); // R8

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strobe)); // R8

  AST_STANDBY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    standbySync |=> $stable(gateQ) && $stable(stateQ)); // R9

  AST_PULSE_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    pulseCntQ <= PC_W'(PULSE_CYCLES)); // R11

  AST_CONT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (stateQ == ST_RUN) && cfgContinuous && !standbySync && !intrRise |=> outGate); // R6
endmodule

// File: rtl/burst_sweep_seq.sv
module burst_sweep_seq
  import sweep_seq_pkg::*;
#(
  parameter int FREQ_W       = 24,
  parameter int CNT_W        = 12,
  parameter int SYNC_STAGES  = 2,
  parameter int PULSE_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgContinuous,
  input  logic              cfgExtBurst,
  input  logic              cfgExtIncr,
  input  logic              statusEnable,
  input  logic              statusMode,
  input  logic [FREQ_W-1:0] startFreq,
  input  logic [FREQ_W-1:0] deltaFreq,
  input  logic [CNT_W-1:0]  numIncr,
  input  logic              ctrlPin,
  input  logic              intrPin,
  input  logic              standbyPin,
  output logic [FREQ_W-1:0] freqWord,
  output logic              outGate,
  output logic              accumEnable,
  output logic              statusOut
);
  logic      ctrlSync, intrSync, standbySync, atEnd;
  dpStrobe_t strobe;

  sweep_pin_sync #(.STAGES(SYNC_STAGES)) ctrlSync_i (
    .clk(clk), .rst_n(rst_n), .pinAsync(ctrlPin), .pinSync(ctrlSync));
  sweep_pin_sync #(.STAGES(SYNC_STAGES)) intrSync_i (
    .clk(clk), .rst_n(rst_n), .pinAsync(intrPin), .pinSync(intrSync));
  sweep_pin_sync #(.STAGES(SYNC_STAGES)) stbySync_i (
    .clk(clk), .rst_n(rst_n), .pinAsync(standbyPin), .pinSync(standbySync));

  sweep_seq_ctrl #(.PULSE_CYCLES(PULSE_CYCLES)) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .ctrlSync(ctrlSync), .intrSync(intrSync), .standbySync(standbySync),
    .cfgContinuous(cfgContinuous), .cfgExtBurst(cfgExtBurst), .cfgExtIncr(cfgExtIncr),
    .statusEnable(statusEnable), .statusMode(statusMode), .atEnd(atEnd),
    .strobe(strobe), .outGate(outGate), .accumEnable(accumEnable), .statusOut(statusOut));

  sweep_freq_path #(.FREQ_W(FREQ_W), .CNT_W(CNT_W)) path_i (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .startFreq(startFreq), .deltaFreq(deltaFreq), .numIncr(numIncr),
    .freqWord(freqWord), .atEnd(atEnd));
endmodule

// File: tb/burst_sweep_seq_tb_top.sv
`timescale 1ns/1ps
module burst_sweep_seq_tb_top;
  localparam int FW = 24;
  localparam int CW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfgContinuous = 0, cfgExtBurst = 1, cfgExtIncr = 1;
  logic statusEnable = 0, statusMode = 0;
  logic [FW-1:0] startFreq = '0, deltaFreq = '0;
  logic [CW-1:0] numIncr = '0;
  logic ctrlPin = 0, intrPin = 0, standbyPin = 0;
  logic [FW-1:0] freqWord;
  logic outGate, accumEnable, statusOut;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  burst_sweep_seq dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfgContinuous(cfgContinuous), .cfgExtBurst(cfgExtBurst), .cfgExtIncr(cfgExtIncr),
    .statusEnable(statusEnable), .statusMode(statusMode),
    .startFreq(startFreq), .deltaFreq(deltaFreq), .numIncr(numIncr),
    .ctrlPin(ctrlPin), .intrPin(intrPin), .standbyPin(standbyPin),
    .freqWord(freqWord), .outGate(outGate), .accumEnable(accumEnable), .statusOut(statusOut));

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (5) @(posedge clk);
    #1;
  endtask

  task automatic pulseIntr();
    intrPin = 1; settle();
    intrPin = 0; settle();
  endtask

  task automatic ctrlEdge();
    ctrlPin = 0; settle();
    ctrlPin = 1; settle();
  endtask

  task automatic t_reset();
    chk("R1 freqWord", int'(freqWord), 0);
    chk("R1 outGate", int'(outGate), 0);
    chk("R1 accumEnable", int'(accumEnable), 0);
    chk("R1 statusOut", int'(statusOut), 0);
  endtask

  task automatic t_burst_up();
    cfgContinuous = 0; cfgExtBurst = 1; cfgExtIncr = 1;
    statusEnable = 1; statusMode = 0;
    startFreq = 1000; deltaFreq = 250; numIncr = 3;
    pulseIntr();
    ctrlEdge();
    chk("R2 start freq", int'(freqWord), 1000);
    chk("R2 gate high", int'(outGate), 1);
    chk("R2 accum on", int'(accumEnable), 1);
    chk("R12 not at end", int'(statusOut), 0);
    ctrlPin = 0; settle();
    chk("R3 gate midscale", int'(outGate), 0);
    chk("R3 accum on", int'(accumEnable), 1);
    ctrlPin = 1; settle();
    chk("R4 step 1", int'(freqWord), 1250);
    chk("R4 gate", int'(outGate), 1);
    ctrlEdge();
    chk("R4 step 2", int'(freqWord), 1500);
    ctrlEdge();
    chk("R4 step 3", int'(freqWord), 1750);
    chk("R12 end level", int'(statusOut), 1);
    ctrlEdge();
    chk("R5 hold at end", int'(freqWord), 1750);
    ctrlPin = 0; settle();
  endtask

  task automatic t_burst_down();
    startFreq = 5000; deltaFreq = FW'(-100); numIncr = 2;
    statusEnable = 0;
    pulseIntr();
    ctrlEdge();
    chk("R4 neg start", int'(freqWord), 5000);
    ctrlEdge();
    chk("R4 neg step", int'(freqWord), 4900);
    ctrlEdge();
    chk("R4 neg step 2", int'(freqWord), 4800);
    ctrlEdge();
    chk("R5 neg hold", int'(freqWord), 4800);
    chk("R10 status off", int'(statusOut), 0);
    ctrlPin = 0; settle();
  endtask

  task automatic t_continuous();
    cfgContinuous = 1; startFreq = 300; deltaFreq = 7; numIncr = 5;
    pulseIntr();
    ctrlEdge();
    ctrlPin = 0; settle();
    chk("R6 gate while low", int'(outGate), 1);
    ctrlPin = 1; settle();
    chk("R6 step", int'(freqWord), 307);
    chk("R6 gate high", int'(outGate), 1);
    ctrlPin = 0; settle();
    cfgContinuous = 0;
  endtask

  task automatic t_no_incr();
    cfgExtIncr = 0; startFreq = 800; deltaFreq = 9; numIncr = 5;
    pulseIntr();
    ctrlEdge();
    ctrlEdge();
    ctrlEdge();
    chk("R7 no step", int'(freqWord), 800);
    chk("R7 gate follows", int'(outGate), 1);
    ctrlPin = 0; settle();
    cfgExtIncr = 1;
  endtask

  task automatic t_interrupt();
    startFreq = 1200; deltaFreq = 10; numIncr = 4;
    pulseIntr();
    ctrlEdge();
    chk("R8 running", int'(outGate), 1);
    intrPin = 1; settle();
    chk("R8 gate midscale", int'(outGate), 0);
    chk("R8 accum off", int'(accumEnable), 0);
    chk("R8 freq cleared", int'(freqWord), 0);
    intrPin = 0; ctrlPin = 0; settle();
    intrPin = 1; ctrlPin = 1; settle();
    chk("R8 priority gate", int'(outGate), 0);
    chk("R8 priority freq", int'(freqWord), 0);
    intrPin = 0; ctrlPin = 0; settle();
  endtask

  task automatic t_standby();
    startFreq = 2000; deltaFreq = 50; numIncr = 4;
    pulseIntr();
    ctrlEdge();
    ctrlPin = 0; settle();
    standbyPin = 1; settle();
    chk("R9 accum off", int'(accumEnable), 0);
    ctrlPin = 1; settle();
    chk("R9 freq held", int'(freqWord), 2000);
    chk("R9 gate held", int'(outGate), 0);
    standbyPin = 0; settle();
    chk("R9 resume step", int'(freqWord), 2050);
    chk("R9 resume gate", int'(outGate), 1);
    chk("R9 accum on", int'(accumEnable), 1);
    ctrlPin = 0; settle();
  endtask

  task automatic countStatus(output int n);
    n = 0;
    for (int i = 0; i < 20; i++) begin
      @(posedge clk); #1;
      if (statusOut) n++;
    end
  endtask

  task automatic t_status_pulse();
    int n;
    statusEnable = 1; statusMode = 1;
    startFreq = 100; deltaFreq = 1; numIncr = 4;
    pulseIntr();
    ctrlPin = 1; countStatus(n);
    chk("R11 no pulse on start", n, 0);
    ctrlPin = 0; settle();
    ctrlPin = 1; countStatus(n);
    chk("R11 pulse length", n, 4);
    ctrlPin = 0; settle();
    statusEnable = 0;
    ctrlPin = 1; countStatus(n);
    chk("R10 disabled pulse", n, 0);
    chk("R10 step taken", int'(freqWord), 102);
    ctrlPin = 0; settle();
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    settle();
    t_reset();
    t_burst_up();
    t_burst_down();
    t_continuous();
    t_no_incr();
    t_interrupt();
    t_standby();
    t_status_pulse();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule